// File: doc/BRIEF.md
# Stereo I2S Sine Test-Tone Source

This block produces a steady sine test tone for level matching and A/B listening checks. It sends the tone as a stereo I2S stream to an external audio transmitter. It runs from a single master clock at 256 times the 44.1 kHz sample rate. The bit clock and the word-select clock are both divided down from that master clock, so their phase relation is fixed. Each frame carries one sine sample from an on-chip table, and the same 16-bit word goes out on both channels.

There are two tones, chosen with `tone_sel`. The short table has 44 entries and holds one period, which gives about 1002 Hz. The long table has 441 entries and holds exactly five periods, which gives exactly 500 Hz. Each table is stored as four segments with consecutive addresses. The sequencer reads them as one unbroken run, so no entry is skipped or played twice where one segment meets the next. The sequencer samples `tone_sel` only when the table wraps, so a period is never cut short.

A synchronous clear, `sync_clr`, puts the divider chain, the serializer and the table address into a known phase. The bit clock and word select then always start from the same point relative to the master clock. After a clear or a reset, the first frame is all zeros. Table entry 0 goes out in the frame that follows.

Top module: `tone_i2s_gen`

## Requirements
- R1: `i2s_bclk` is `mclk` divided by 4 with equal high and low time. `i2s_ws` changes only on a falling edge of `i2s_bclk` and toggles every 32 bit clocks. `i2s_ws` is low for the left channel, so a frame is 256 `mclk` cycles.
- R2: Each channel slot carries a 16-bit two's-complement word, MSB first. The MSB goes out in the second bit clock after the word-select edge (slot 1), and the LSB goes out in slot 16. Slot 0 and slots 17 to 31 are 0. `i2s_sd` changes only on a falling edge of `i2s_bclk`.
- R3: The right-channel word of a frame equals the left-channel word of the same frame.
- R4: With `tone_sel` = 0 (short tone), entry i (0..43) equals round(30000 * sin(2*pi*i/44)).
- R5: With `tone_sel` = 1 (long tone), entry i (0..440) equals round(30000 * sin(2*pi*5*i/441)).
- R6: Each table is held as four segments of ceil(N/4) entries, and the last segment takes the remainder. The segments are read as one continuous sequence. Every step moves the linear index up by exactly one across segment boundaries.
- R7: The table address advances once per frame, at the word-select edge that opens the left channel. It wraps from the last entry to 0.
- R8: `tone_sel` is sampled only when the table wraps, at reset, and at a clear. A change between those points has no effect on the samples sent.
- R9: The cycle that parallel-loads the shift register does not shift. The loaded word reaches `i2s_sd` intact, starting in slot 1.
- R10: In the cycle after an `mclk` edge with `sync_clr` high, `i2s_bclk`, `i2s_ws` and `i2s_sd` are 0. `i2s_bclk` first rises 2 cycles later, and `i2s_ws` first rises 128 cycles later. The first frame after a clear is all zeros, and entry 0 follows in the next frame.
- R11: `rst_n` is a synchronous, active-low reset. It has the same effect as `sync_clr` and loads the tone mode from `tone_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of divider phase and sequencing |
| tone_sel | input | 1 | Tone choice: 0 = 44-entry table, 1 = 441-entry table |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select, low = left channel |
| i2s_sd | output | 1 | Serial audio data |

## Verification
The in-RTL assertions check timing and ordering rules on every cycle. Word select and data move only on bit-clock falling edges. A load is never merged with a shift. The table index steps by exactly one across segment borders and returns to zero only at a wrap. The tone mode holds still between wraps. Only the bench's scenarios can show the numeric content of both tables in full, the delay from a clear to the first word-select rise, and that a `tone_sel` change in mid-period leaves the short tone running until its last entry.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int NUM_SEG   = 4;
  localparam int SHORT_LEN = 44;
  localparam int SHORT_CYC = 1;
  localparam int LONG_LEN  = 441;
  localparam int LONG_CYC  = 5;
  localparam int TONE_AMP  = 30000;

  // entries per segment, rounded up
  function automatic int seg_span(input int len, input int nseg);
    return (len + nseg - 1) / nseg;
  endfunction

  // entries actually held by segment s (the last one takes the remainder)
  function automatic int seg_size(input int len, input int nseg, input int s);
    int span;
    span = seg_span(len, nseg);
    if (s == nseg - 1) return len - (nseg - 1) * span;
    return span;
  endfunction

  // rounded sine code for linear entry idx of a table holding cyc periods
  function automatic logic signed [SAMPLE_W-1:0] sine_code(input int idx, input int len,
                                                           input int cyc, input int amp);
    real ang;
    real v;
    int  q;
    ang = 6.283185307179586 * real'(idx * cyc) / real'(len);
    v   = real'(amp) * $sin(ang);
    if (v >= 0.0) q = $rtoi(v + 0.5);
    else          q = -$rtoi(0.5 - v);
    return q[SAMPLE_W-1:0];
  endfunction

  // bit-clock level for a master-clock count inside the frame
  function automatic logic bclk_level(input int cnt, input int mclk_per_bit);
    return (cnt % mclk_per_bit) >= (mclk_per_bit / 2);
  endfunction

endpackage

// File: rtl/tone_clk_div.sv
module tone_clk_div
  import tone_pkg::*;
#(
  parameter int MCLK_PER_BIT = 4,
  parameter int BITS_PER_CH  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic bclk_o,
  output logic ws_o,
  output logic fall_tick_o,
  output logic half_tick_o,
  output logic frame_tick_o
);

  localparam int FRAME_MCLK = MCLK_PER_BIT * 2 * BITS_PER_CH;
  localparam int CNT_W      = $clog2(FRAME_MCLK);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (int'(cnt_q) == FRAME_MCLK - 1) cnt_nxt = '0;
    else                               cnt_nxt = cnt_q + 1'b1;
  end

  // named events: next edge is a bit-clock fall / channel start / frame start
  assign fall_tick_o  = (int'(cnt_q) % MCLK_PER_BIT) == MCLK_PER_BIT - 1;
  assign half_tick_o  = int'(cnt_q) == FRAME_MCLK / 2 - 1;
  assign frame_tick_o = int'(cnt_q) == FRAME_MCLK - 1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      bclk_o <= bclk_level(int'(cnt_nxt), MCLK_PER_BIT);
      ws_o   <= int'(cnt_nxt) >= FRAME_MCLK / 2;
    end
  end

  // R1
  ws_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && (ws_o != $past(ws_o))) |-> $fell(bclk_o));

  // R1
  frame_start_left_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    frame_tick_o |=> (!ws_o && !bclk_o));

  // R1
  bclk_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(bclk_o) |=> bclk_o);

endmodule

// File: rtl/tone_table.sv
module tone_table
  import tone_pkg::*;
#(
  parameter int LEN   = 44,
  parameter int CYC   = 1,
  parameter int AMP   = 30000,
  parameter int NSEG  = 4,
  parameter int SEG_W = 2,
  parameter int OFF_W = 7
) (
  input  logic [SEG_W-1:0]           seg_i,
  input  logic [OFF_W-1:0]           off_i,
  output logic signed [SAMPLE_W-1:0] data_o
);

  localparam int SPAN   = seg_span(LEN, NSEG);
  localparam int LOC_OW = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic signed [SAMPLE_W-1:0] rom [NSEG][SPAN];
  logic [LOC_OW-1:0]          off_loc;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    for (genvar o = 0; o < SPAN; o++) begin : g_ent
      localparam int LIN = s * SPAN + o;
      if (LIN < LEN) begin : g_used
        assign rom[s][o] = sine_code(LIN, LEN, CYC, AMP);
      end else begin : g_pad
        assign rom[s][o] = '0;
      end
    end
  end

  assign off_loc = off_i[LOC_OW-1:0];

  always_comb data_o = rom[seg_i][off_loc];

endmodule

// File: rtl/tone_addr_seq.sv
module tone_addr_seq
  import tone_pkg::*;
#(
  parameter int S_LEN = 44,
  parameter int L_LEN = 441,
  parameter int NSEG  = 4,
  parameter int SEG_W = 2,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv_i,
  input  logic             sel_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o,
  output logic             long_o
);

  localparam int S_SPAN = seg_span(S_LEN, NSEG);
  localparam int L_SPAN = seg_span(L_LEN, NSEG);

  logic [OFF_W-1:0] last_s [NSEG];
  logic [OFF_W-1:0] last_l [NSEG];
  logic [OFF_W-1:0] last_off;
  logic             at_seg_end;
  logic             at_last_seg;
  logic             wrap_stb;

  for (genvar s = 0; s < NSEG; s++) begin : g_last
    assign last_s[s] = OFF_W'(seg_size(S_LEN, NSEG, s) - 1);
    assign last_l[s] = OFF_W'(seg_size(L_LEN, NSEG, s) - 1);
  end

  assign last_off    = long_o ? last_l[seg_o] : last_s[seg_o];
  assign at_seg_end  = off_o == last_off;
  assign at_last_seg = seg_o == SEG_W'(NSEG - 1);
  assign wrap_stb    = adv_i && at_seg_end && at_last_seg;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      seg_o  <= '0;
      off_o  <= '0;
      long_o <= sel_i;
    end else if (adv_i) begin
      if (at_seg_end) begin
        off_o <= '0;
        if (at_last_seg) begin
          seg_o  <= '0;
          long_o <= sel_i;
        end else begin
          seg_o <= seg_o + 1'b1;
        end
      end else begin
        off_o <= off_o + 1'b1;
      end
    end
  end

  // linear view of the two-level address, for the checks below
  int lin_idx;
  int cur_len;
  assign lin_idx = int'(seg_o) * (long_o ? L_SPAN : S_SPAN) + int'(off_o);
  assign cur_len = long_o ? L_LEN : S_LEN;

  // R6
  step_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(adv_i) && !$past(wrap_stb))
      |-> (lin_idx == $past(lin_idx) + 1));

  // R6
  off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_o <= last_off);

  // R7
  wrap_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    wrap_stb |-> ((lin_idx == cur_len - 1) ##1 (lin_idx == 0)));

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !$past(adv_i)) |-> ($stable(seg_o) && $stable(off_o)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !$past(wrap_stb)) |-> $stable(long_o));

endmodule

// File: rtl/tone_serializer.sv
module tone_serializer
  import tone_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       fall_tick_i,
  input  logic                       half_tick_i,
  input  logic                       frame_tick_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       sd_o
);

  logic [SAMPLE_W-1:0] sreg_q;
  logic [SAMPLE_W-1:0] hold_q;
  logic                load_stb;
  logic                shift_stb;

  // a new channel starts at the next bit-clock fall: load, and blank the shift
  assign load_stb  = fall_tick_i && (frame_tick_i || half_tick_i);
  assign shift_stb = fall_tick_i && !load_stb;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sreg_q <= '0;
      hold_q <= '0;
      sd_o   <= 1'b0;
    end else if (load_stb) begin
      sd_o <= 1'b0;
      if (frame_tick_i) begin
        sreg_q <= sample_i;
        hold_q <= sample_i;
      end else begin
        sreg_q <= hold_q;
      end
    end else if (shift_stb) begin
      sd_o   <= sreg_q[SAMPLE_W-1];
      sreg_q <= {sreg_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  // R9
  load_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(load_stb))
      |-> ((sreg_q == ($past(frame_tick_i) ? $past(sample_i) : $past(hold_q))) && !sd_o));

  // R2
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !$past(fall_tick_i)) |-> $stable(sd_o));

  // R3
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !$past(frame_tick_i)) |-> $stable(hold_q));

endmodule

// File: rtl/tone_i2s_gen.sv
module tone_i2s_gen
  import tone_pkg::*;
#(
  parameter int MCLK_PER_BIT = 4,
  parameter int BITS_PER_CH  = 32
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic tone_sel,
  output logic i2s_bclk,
  output logic i2s_ws,
  output logic i2s_sd
);

  localparam int SEG_W = $clog2(NUM_SEG);
  localparam int OFF_W = $clog2(seg_span(LONG_LEN, NUM_SEG));

  logic                       fall_tick;
  logic                       half_tick;
  logic                       frame_tick;
  logic [SEG_W-1:0]           seg;
  logic [OFF_W-1:0]           off;
  logic                       mode_long;
  logic signed [SAMPLE_W-1:0] short_data;
  logic signed [SAMPLE_W-1:0] long_data;
  logic signed [SAMPLE_W-1:0] cur_sample;

  tone_clk_div #(
    .MCLK_PER_BIT (MCLK_PER_BIT),
    .BITS_PER_CH  (BITS_PER_CH)
  ) u_div (
    .clk          (mclk),
    .rst_n        (rst_n),
    .clr          (sync_clr),
    .bclk_o       (i2s_bclk),
    .ws_o         (i2s_ws),
    .fall_tick_o  (fall_tick),
    .half_tick_o  (half_tick),
    .frame_tick_o (frame_tick)
  );

  tone_addr_seq #(
    .S_LEN (SHORT_LEN),
    .L_LEN (LONG_LEN),
    .NSEG  (NUM_SEG),
    .SEG_W (SEG_W),
    .OFF_W (OFF_W)
  ) u_seq (
    .clk    (mclk),
    .rst_n  (rst_n),
    .clr    (sync_clr),
    .adv_i  (frame_tick),
    .sel_i  (tone_sel),
    .seg_o  (seg),
    .off_o  (off),
    .long_o (mode_long)
  );

  tone_table #(
    .LEN   (SHORT_LEN),
    .CYC   (SHORT_CYC),
    .AMP   (TONE_AMP),
    .NSEG  (NUM_SEG),
    .SEG_W (SEG_W),
    .OFF_W (OFF_W)
  ) u_short (
    .seg_i  (seg),
    .off_i  (off),
    .data_o (short_data)
  );

  tone_table #(
    .LEN   (LONG_LEN),
    .CYC   (LONG_CYC),
    .AMP   (TONE_AMP),
    .NSEG  (NUM_SEG),
    .SEG_W (SEG_W),
    .OFF_W (OFF_W)
  ) u_long (
    .seg_i  (seg),
    .off_i  (off),
    .data_o (long_data)
  );

  assign cur_sample = mode_long ? long_data : short_data;

  tone_serializer u_ser (
    .clk          (mclk),
    .rst_n        (rst_n),
    .clr          (sync_clr),
    .fall_tick_i  (fall_tick),
    .half_tick_i  (half_tick),
    .frame_tick_i (frame_tick),
    .sample_i     (cur_sample),
    .sd_o         (i2s_sd)
  );

endmodule

// File: tb/tone_i2s_gen_tb.sv
module tone_i2s_gen_tb;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_clr = 1'b0;
  logic tone_sel = 1'b0;
  wire  bclk;
  wire  ws;
  wire  sd;

  int checks = 0;
  int failures = 0;

  localparam real TWO_PI = 6.283185307179586;
  localparam int  NVEC = 3;
  // {tone_sel, frames to run}
  localparam logic [16:0] VEC [NVEC] = '{ {1'b0, 16'd30}, {1'b1, 16'd20}, {1'b1, 16'd440} };

  bit m_long;
  int m_idx;
  bit m_prime;

  always #2 mclk = ~mclk;

  tone_i2s_gen u_dut (
    .mclk     (mclk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .tone_sel (tone_sel),
    .i2s_bclk (bclk),
    .i2s_ws   (ws),
    .i2s_sd   (sd)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sample(input bit lng, input int i);
    int  n;
    int  c;
    real v;
    n = lng ? 441 : 44;
    c = lng ? 5 : 1;
    v = 30000.0 * $sin(TWO_PI * real'(c) * real'(i) / real'(n));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  // collects one frame starting at its slot 0; checks word-select and padding
  task automatic grab(output logic [15:0] l, output logic [15:0] r, output bit frm_ok);
    l = '0;
    r = '0;
    frm_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      int slot;
      @(posedge bclk);
      @(negedge mclk);
      slot = i % 32;
      if (ws !== (i >= 32)) frm_ok = 1'b0;
      if (slot >= 1 && slot <= 16) begin
        if (i < 32) l = {l[14:0], sd};
        else        r = {r[14:0], sd};
      end else if (sd !== 1'b0) begin
        frm_ok = 1'b0;
      end
    end
  endtask

  task automatic check_frame();
    logic [15:0] l;
    logic [15:0] r;
    logic [15:0] e;
    bit          fo;
    grab(l, r, fo);
    chk(fo, "R2", "frame ws/padding pattern", int'(fo), 1);
    if (m_prime) begin
      chk(l == 16'h0 && r == 16'h0, "R10", "priming frame zero",
          int'($signed(l)), 0);
    end else begin
      e = 16'(ref_sample(m_long, m_idx));
      if (m_long) chk(l == e, "R5", $sformatf("long entry %0d left", m_idx),
                      int'($signed(l)), int'($signed(e)));
      else        chk(l == e, "R4", $sformatf("short entry %0d left", m_idx),
                      int'($signed(l)), int'($signed(e)));
      chk(r == e, "R3", $sformatf("right equals left, entry %0d", m_idx),
          int'($signed(r)), int'($signed(e)));
    end
  endtask

  // R7, R8: one step per frame, wrap to 0, mode taken at wrap
  task automatic advance(input bit sel_at_tick);
    int n;
    n = m_long ? 441 : 44;
    if (m_prime) begin
      m_prime = 1'b0;
      m_idx = 0;
    end else if (m_idx == n - 1) begin
      m_idx = 0;
      m_long = sel_at_tick;
    end else begin
      m_idx++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge mclk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit nxt;
    int bclk_err;
    int ws_rise;
    tone_sel = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge mclk);
    // R11: reset state
    chk(bclk === 1'b0 && ws === 1'b0 && sd === 1'b0, "R11", "outputs in reset",
        int'({bclk, ws, sd}), 0);
    rst_n = 1'b1;
    m_prime = 1'b1;
    m_idx = 0;
    m_long = 1'b0;

    // vector walk: short tone, mid-period switch (R8), long tone through wrap (R6, R7)
    for (int v = 0; v < NVEC; v++) begin
      tone_sel = VEC[v][16];
      for (int f = 0; f < int'(VEC[v][15:0]); f++) begin
        check_frame();
        nxt = (f == int'(VEC[v][15:0]) - 1 && v + 1 < NVEC) ? VEC[v + 1][16] : VEC[v][16];
        tone_sel = nxt;
        advance(nxt);
      end
    end

    // R10: clear timing, then long tone from entry 0
    tone_sel = 1'b1;
    @(negedge mclk);
    sync_clr = 1'b1;
    @(negedge mclk);
    sync_clr = 1'b0;
    chk(bclk === 1'b0 && ws === 1'b0 && sd === 1'b0, "R10", "outputs after clear",
        int'({bclk, ws, sd}), 0);
    bclk_err = 0;
    ws_rise = -1;
    for (int i = 0; i < 256; i++) begin
      if (bclk !== ((i % 4) >= 2)) bclk_err++;
      if (ws_rise < 0 && ws === 1'b1) ws_rise = i;
      if (ws !== (i >= 128)) bclk_err++;
      @(negedge mclk);
    end
    chk(bclk_err == 0, "R1", "bclk/ws shape after clear", bclk_err, 0);
    chk(ws_rise == 128, "R10", "cycles to first ws rise", ws_rise, 128);
    m_prime = 1'b0;
    m_idx = 0;
    m_long = 1'b1;
    for (int f = 0; f < 2; f++) begin
      check_frame();
      advance(tone_sel);
    end

    // R8: clear in mid-frame reloads the mode; priming frame, then short entries
    repeat (37) @(negedge mclk);
    tone_sel = 1'b0;
    sync_clr = 1'b1;
    @(negedge mclk);
    sync_clr = 1'b0;
    m_prime = 1'b1;
    m_idx = 0;
    m_long = 1'b0;
    for (int f = 0; f < 4; f++) begin
      check_frame();
      advance(tone_sel);
    end

    // R11: reset in mid-stream loads mode from tone_sel
    repeat (50) @(negedge mclk);
    tone_sel = 1'b1;
    rst_n = 1'b0;
    @(negedge mclk);
    chk(bclk === 1'b0 && ws === 1'b0 && sd === 1'b0, "R11", "outputs in mid-stream reset",
        int'({bclk, ws, sd}), 0);
    rst_n = 1'b1;
    m_prime = 1'b1;
    m_idx = 0;
    m_long = 1'b1;
    for (int f = 0; f < 3; f++) begin
      check_frame();
      advance(tone_sel);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule